// File: doc/BRIEF.md
# False Lock Detector Accumulator

This block watches the quadrature branch of a symbol integrator for a false lock on square-wave data at high signal-to-noise ratio. At each mid-symbol strobe it keeps the integrator value, which is the integral from the previous end of symbol up to mid-symbol. At the next end-of-symbol strobe it compares the magnitude of the full-symbol integral against that held half-symbol magnitude. A symbol whose full-symbol magnitude is strictly smaller is a possible false-lock event. Events are summed into a preloaded accumulator over an integration period that is a programmed number of symbols long. A rollover of the accumulator during the period marks the period as falsely locked.

A source select can make the accumulator sum the magnitude of a frequency error input at each end-of-symbol strobe instead of counting events. When a period ends the block gives a one-cycle done pulse and presents the final count and the rollover flag. Both stay fixed until the next period ends, and a new period starts at once. The strobes are single-cycle qualifiers that the block always accepts. There is no back-pressure, so a valid/ready handshake is not used. The configuration inputs are plain level signals that the block samples at the start of each period.

Top module: `false_lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, fl_flag, fl_count and done read 0 until the first period completes.
- R2: A mid_stb cycle stores q_in (signed two's complement) as the half-symbol value. An end_stb cycle is an event when |q_in| < |stored value|. Equal magnitudes are not an event.
- R3: An end_stb that has no mid_stb since the previous end_stb (or since reset) is never an event.
- R4: With src_sel = 0 each event adds 1 to the accumulator. With src_sel = 1 every counted end_stb adds |freq_err| (signed two's complement) and events are not counted.
- R5: At the start of each period the accumulator is loaded with preload. The reported fl_count is preload plus the period's additions, modulo 2^ACC_W.
- R6: fl_flag reports 1 when the accumulator carried out of its top bit at any addition in the period. The carry record is cleared at the start of the next period.
- R7: A period spans period_len end_stb pulses, and a period_len of 0 acts as 1. done is high for exactly the one cycle after the clock edge that samples the last end_stb of the period.
- R8: fl_count and fl_flag change only together with done and hold their values between periods.
- R9: preload and period_len are sampled only when a period starts. A change during a period takes effect in the following period.
- R10: The most negative q_in value has magnitude 2^(QW-1), larger than that of the most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mid_stb | input | 1 | Mid-symbol strobe; stores q_in |
| end_stb | input | 1 | End-of-symbol strobe; compares and accumulates |
| q_in | input | QW | Quadrature integrator value, signed |
| freq_err | input | FW | Frequency error value, signed |
| src_sel | input | 1 | 0 = count events, 1 = sum frequency error magnitude |
| preload | input | ACC_W | Accumulator start value for each period |
| period_len | input | CNT_W | Symbols per integration period |
| fl_flag | output | 1 | Accumulator rolled over in the last completed period |
| fl_count | output | ACC_W | Final accumulator value of the last completed period |
| done | output | 1 | One-cycle pulse when a period completes |

## Verification
All three results are registered at the same clock edge that samples the period's final end_stb. done, fl_count and fl_flag are therefore due one cycle after that strobe is presented, and done falls again one cycle later. The bench drives each strobe for one full cycle starting at a falling edge. It reads outputs at the falling edge that follows the sampling edge, which is the first point at which the new values are due. It checks done low at the falling edges around the pulse, and it checks that fl_count is unchanged while a period is still in progress.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic {
    SRC_EVENTS = 1'b0,
    SRC_FREQ   = 1'b1
  } fld_src_e;
endpackage

// File: rtl/fld_half_cmp.sv
module fld_half_cmp #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mid_stb,
  input  logic          end_stb,
  input  logic [QW-1:0] q_in,
  output logic          event_o
);
  localparam int MW = QW + 1;

  logic [QW-1:0] half_q;
  logic          half_valid;
  logic [MW-1:0] mag_now;
  logic [MW-1:0] mag_half;

  // sign-extend then negate, so the most negative input fits
  always_comb begin
    mag_now  = q_in[QW-1]   ? (~{q_in[QW-1], q_in} + MW'(1))     : {1'b0, q_in};
    mag_half = half_q[QW-1] ? (~{half_q[QW-1], half_q} + MW'(1)) : {1'b0, half_q};
  end

  assign event_o = end_stb && half_valid && (mag_now < mag_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q     <= '0;
      half_valid <= 1'b0;
    end else begin
      if (end_stb) half_valid <= 1'b0;
      if (mid_stb) begin
        half_q     <= q_in;
        half_valid <= 1'b1;
      end
    end
  end

  p_mid_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |=> (half_valid && half_q == $past(q_in)));

  p_stale_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && !mid_stb) |=> !half_valid);
endmodule

// File: rtl/fld_period_ctr.sv
module fld_period_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_stb,
  input  logic [CNT_W-1:0] period_len,
  output logic             load,
  output logic             count_en,
  output logic             expire,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             idle;

  assign idle     = (cnt == '0);
  assign count_en = end_stb && !idle;
  assign expire   = count_en && (cnt == CNT_W'(1));
  assign load     = idle || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= expire;
      if (load)
        cnt <= (period_len == '0) ? CNT_W'(1) : period_len;
      else if (end_stb)
        cnt <= cnt - CNT_W'(1);
    end
  end

  p_done_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(end_stb));

  p_decrement_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_stays_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !idle);
endmodule

// File: rtl/fld_accum.sv
module fld_accum #(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] preload,
  input  logic             add_en,
  input  logic [ACC_W-1:0] add_val,
  input  logic             expire,
  output logic [ACC_W-1:0] res_count,
  output logic             res_flag
);
  logic [ACC_W-1:0] acc;
  logic             sticky;
  logic [ACC_W:0]   sum_w;
  logic             carry;

  assign sum_w = add_en ? ({1'b0, acc} + {1'b0, add_val}) : {1'b0, acc};
  assign carry = sum_w[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      sticky    <= 1'b0;
      res_count <= '0;
      res_flag  <= 1'b0;
    end else begin
      if (expire) begin
        res_count <= sum_w[ACC_W-1:0];
        res_flag  <= sticky | carry;
      end
      if (load) begin
        acc    <= preload;
        sticky <= 1'b0;
      end else if (add_en) begin
        acc    <= sum_w[ACC_W-1:0];
        sticky <= sticky | carry;
      end
    end
  end

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> $past(load));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> ($stable(res_count) && $stable(res_flag)));

  p_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc == $past(preload) && !sticky));
endmodule

// File: rtl/false_lock_monitor.sv
module false_lock_monitor #(
  parameter int QW    = 16,
  parameter int FW    = 16,
  parameter int ACC_W = 20,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mid_stb,
  input  logic             end_stb,
  input  logic [QW-1:0]    q_in,
  input  logic [FW-1:0]    freq_err,
  input  logic             src_sel,
  input  logic [ACC_W-1:0] preload,
  input  logic [CNT_W-1:0] period_len,
  output logic             fl_flag,
  output logic [ACC_W-1:0] fl_count,
  output logic             done
);
  import fld_pkg::*;

  localparam int FMW = FW + 1;

  logic             evt;
  logic             load;
  logic             count_en;
  logic             expire;
  logic [FMW-1:0]   fmag;
  logic [ACC_W-1:0] inc;
  fld_src_e         src;

  assign src  = fld_src_e'(src_sel);
  assign fmag = freq_err[FW-1] ? (~{freq_err[FW-1], freq_err} + FMW'(1))
                               : {1'b0, freq_err};

  generate
    if (FMW <= ACC_W) begin : g_fit
      assign inc = (src == SRC_FREQ) ? ACC_W'(fmag) : ACC_W'(evt);
    end else begin : g_clip
      assign inc = (src == SRC_FREQ) ? fmag[ACC_W-1:0] : ACC_W'(evt);
    end
  endgenerate

  fld_half_cmp #(.QW(QW)) u_half (
    .clk(clk), .rst_n(rst_n), .mid_stb(mid_stb), .end_stb(end_stb),
    .q_in(q_in), .event_o(evt)
  );

  fld_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .end_stb(end_stb), .period_len(period_len),
    .load(load), .count_en(count_en), .expire(expire), .done(done)
  );

  fld_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .preload(preload),
    .add_en(count_en), .add_val(inc), .expire(expire),
    .res_count(fl_count), .res_flag(fl_flag)
  );

  p_event_needs_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> end_stb);

  p_outputs_move_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fl_count) && $stable(fl_flag)));
endmodule

// File: tb/false_lock_monitor_tb.sv
module false_lock_monitor_tb;
  localparam int QW = 16, FW = 16, ACC_W = 20, CNT_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mid_stb = 1'b0, end_stb = 1'b0, src_sel = 1'b0;
  logic [QW-1:0] q_in = '0;
  logic [FW-1:0] freq_err = '0;
  logic [ACC_W-1:0] preload = '0;
  logic [CNT_W-1:0] period_len = CNT_W'(1);
  logic fl_flag, done;
  logic [ACC_W-1:0] fl_count;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  false_lock_monitor #(.QW(QW), .FW(FW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mid_stb(mid_stb), .end_stb(end_stb),
    .q_in(q_in), .freq_err(freq_err), .src_sel(src_sel), .preload(preload),
    .period_len(period_len), .fl_flag(fl_flag), .fl_count(fl_count), .done(done)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic restart(input int pl, input int per, input logic src);
    @(negedge clk);
    rst_n = 1'b0; mid_stb = 0; end_stb = 0;
    preload = ACC_W'(pl); period_len = CNT_W'(per); src_sel = src;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // mid strobe with a, then end strobe with b; returns at the falling edge
  // after the edge that sampled the end strobe
  task automatic sym(input int a, input int b, input int fe);
    mid_stb = 1; q_in = QW'(a);
    @(negedge clk);
    mid_stb = 0; end_stb = 1; q_in = QW'(b); freq_err = FW'(fe);
    @(negedge clk);
    end_stb = 0;
  endtask

  task automatic end_only(input int b);
    end_stb = 1; q_in = QW'(b);
    @(negedge clk);
    end_stb = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset flag", fl_flag, 0);
    check("R1 reset count", fl_count, 0);
    check("R1 reset done", done, 0);
    restart(0, 4, 0);
    check("R1 after release count", fl_count, 0);
    check("R1 after release done", done, 0);
  endtask

  task automatic t_events;
    restart(0, 4, 0);
    sym(100, 50, 0);
    check("R7 no early done", done, 0);
    sym(100, 100, 0);
    sym(100, -150, 0);
    sym(-200, 199, 0);
    check("R7 done at period end", done, 1);
    check("R2 event count", fl_count, 2);
    check("R6 no rollover", fl_flag, 0);
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    sym(100, 1, 0);
    sym(100, 1, 0);
    check("R8 count held mid period", fl_count, 2);
  endtask

  task automatic t_stale;
    restart(0, 3, 0);
    sym(100, 50, 0);
    end_only(10);
    end_only(0);
    check("R3 stale half ignored", fl_count, 1);
    check("R7 done after three", done, 1);
  endtask

  task automatic t_freq;
    restart(10, 3, 1);
    sym(100, 50, -5);
    sym(100, 50, 7);
    sym(100, 50, -100);
    check("R4 freq magnitude sum", fl_count, 122);
    check("R4 freq done", done, 1);
  endtask

  task automatic t_rollover;
    restart(20'hFFFFE, 4, 0);
    sym(100, 1, 0);
    sym(100, 1, 0);
    sym(100, 1, 0);
    sym(1, 100, 0);
    check("R5 wrapped count", fl_count, 1);
    check("R6 rollover flag", fl_flag, 1);
    for (int i = 0; i < 4; i++) sym(1, 100, 0);
    check("R6 flag cleared next period", fl_flag, 0);
    check("R5 preload restored", fl_count, 20'hFFFFE);
  endtask

  task automatic t_zero_len;
    restart(0, 0, 0);
    sym(100, 50, 0);
    check("R7 zero length done", done, 1);
    check("R7 zero length count", fl_count, 1);
    @(negedge clk);
    check("R7 zero length pulse ends", done, 0);
  endtask

  task automatic t_config_timing;
    restart(0, 2, 0);
    sym(100, 50, 0);
    preload = ACC_W'(100); period_len = CNT_W'(3);
    sym(100, 50, 0);
    check("R9 old preload used", fl_count, 2);
    check("R9 old length used", done, 1);
    sym(100, 50, 0);
    sym(100, 100, 0);
    check("R9 new length no early done", done, 0);
    sym(100, 50, 0);
    check("R9 new preload used", fl_count, 102);
  endtask

  task automatic t_extreme;
    restart(0, 2, 0);
    sym(-32768, 32767, 0);
    sym(32767, -32768, 0);
    check("R10 most negative magnitude", fl_count, 1);
  endtask

  initial begin
    t_reset();
    t_events();
    t_stale();
    t_freq();
    t_rollover();
    t_zero_len();
    t_config_timing();
    t_extreme();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule